// File: doc/BRIEF.md
# Wrapping Frame Counter with Deferred Start Reload

This block keeps the number of the current frame in a circular buffer. Each single-cycle frame-done strobe moves the count up by one. When the count equals the programmed last frame, that strobe makes it roll over to the programmed start frame instead. Software programs the start and last frames one byte at a time. A frame value takes effect only when its most significant byte is written; the lower bytes wait in a staging register until then.

A hold input sets what a new start frame does to the running count. With hold low, committing a start value makes the counter jump to it at once. With hold high, the start register takes the new value, the counter keeps counting, and a pending flag is raised. The next roll-over then reloads from the new value and clears the flag. Software can read the live count one byte at a time. Reading the low byte captures the upper byte, so a later read of the upper byte belongs to the same count.

Top module: `frame_wrap_counter`

## Requirements
- R1: After synchronous reset the count equals parameter START_RST, the start register equals START_RST, the last register equals LAST_RST, and both the pending flag and the wrap pulse are 0.
- R2: A frame-done strobe while the count differs from the last register, with no start commit, raises the count by one modulo 2^16 in the next cycle. Without a strobe or a commit, the count stays the same.
- R3: A frame-done strobe while the count equals the last register, with no start commit, loads the start register into the count and clears the pending flag. The wrap pulse is high in exactly the following cycle.
- R4: A write to a low byte (address bit 0 = 0: 3'b010 for start, 3'b100 for last) changes neither the count, the start register, the last register nor the pending flag.
- R5: A write to address 3'b011 (start, upper byte) with hold low sets the start register and the count to {data, staged low byte} in the next cycle. This wins over a frame-done strobe in the same cycle and clears pending.
- R6: A write to 3'b011 with hold high updates the start register but not the count, which still follows R2. If no roll-over happens in the same cycle, pending is 1 in the next cycle.
- R7: While pending is set, the next roll-over loads the newly committed start value and clears pending.
- R8: A roll-over in the same cycle as a 3'b011 write with hold high reloads the count from the value being committed and leaves pending at 0.
- R9: A write to 3'b101 (last, upper byte) sets the last register to {data, staged low byte} without moving the count. The next roll-over test uses the new value.
- R10: rd_data shows the live count's low byte for rd_addr 3'b000. An rd_en strobe at 3'b000 captures the count's upper byte, and rd_addr 3'b001 returns that captured byte even after the count has moved.
- R11: rd_data shows the start register's low and upper byte for rd_addr 3'b010 and 3'b011, the last register's bytes for 3'b100 and 3'b101, and 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: [2:1] target (1 start, 2 last), [0] byte index |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe; at address 3'b000 it captures the upper byte of the count |
| rd_addr | input | 3 | Read address, same layout as wr_addr; target 0 is the count |
| rd_data | output | 8 | Combinational read byte |
| hold | input | 1 | Start-write block: defers a new start to the next roll-over |
| frame_done | input | 1 | Single-cycle frame completion strobe |
| cur_frame | output | 16 | Current frame count |
| start_pending | output | 1 | A deferred start value waits for a roll-over |
| wrap_pulse | output | 1 | High for the cycle after a roll-over |

## Verification
The hardest case to reach is a roll-over that falls in exactly the cycle where the start's upper byte is committed with hold set. The count has to be sitting on the last frame at that moment, and the strobe and the write have to arrive together. A directed sequence walks the count to a known last frame and then issues both at once. Random traffic keeps the start and last frames small, so roll-overs and deferred commits overlap often.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
    localparam int BYTE_W   = 8;
    localparam int FRAME_W  = 16;
    localparam int NBYTES   = FRAME_W / BYTE_W;
    localparam int IDX_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam int ADDR_W   = 2 + IDX_W;
    localparam int LOW_W    = FRAME_W - BYTE_W;
    localparam int TOP_IDX  = NBYTES - 1;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [BYTE_W-1:0]  byte_t;

    typedef enum logic [1:0] {
        TGT_CUR   = 2'd0,
        TGT_START = 2'd1,
        TGT_LAST  = 2'd2,
        TGT_NONE  = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [IDX_W-1:0] idx;
    } addr_t;

    typedef enum logic [1:0] {
        ACT_KEEP,
        ACT_STEP,
        ACT_LOAD_NEW,
        ACT_LOAD_OLD
    } act_e;

    function automatic tgt_e tgt_of(input int t);
        return (t == 0) ? TGT_START : TGT_LAST;
    endfunction

    function automatic byte_t pick_byte(input frame_t v, input logic [IDX_W-1:0] i);
        return v[i*BYTE_W +: BYTE_W];
    endfunction

    function automatic frame_t frame_inc(input frame_t v);
        return v + frame_t'(1);
    endfunction
endpackage

// File: rtl/fwc_regfile.sv
module fwc_regfile
    import fwc_pkg::*;
#(
    parameter frame_t START_RST = '0,
    parameter frame_t LAST_RST  = '1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  addr_t  wr_addr,
    input  byte_t  wr_data,
    output frame_t start_q,
    output frame_t last_q,
    output logic   start_commit,
    output frame_t start_new
);
    frame_t             val_q   [2];
    logic [LOW_W-1:0]   stage_q [2];
    logic               commit  [2];

    for (genvar t = 0; t < 2; t++) begin : g_reg
        localparam frame_t RST_V = (t == 0) ? START_RST : LAST_RST;
        logic hit;
        assign hit       = wr_en && (wr_addr.tgt == tgt_of(t));
        assign commit[t] = hit && (wr_addr.idx == IDX_W'(TOP_IDX));

        for (genvar b = 0; b < NBYTES - 1; b++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stage_q[t][b*BYTE_W +: BYTE_W] <= '0;
                else if (hit && wr_addr.idx == IDX_W'(b))
                    stage_q[t][b*BYTE_W +: BYTE_W] <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (rst)
                val_q[t] <= RST_V;
            else if (commit[t])
                val_q[t] <= {wr_data, stage_q[t]};
        end
    end

    assign start_q      = val_q[0];
    assign last_q       = val_q[1];
    assign start_commit = commit[0];
    assign start_new    = {wr_data, stage_q[0]};
endmodule

// File: rtl/fwc_count_core.sv
module fwc_count_core
    import fwc_pkg::*;
#(
    parameter frame_t START_RST = '0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   frame_done,
    input  logic   hold,
    input  logic   start_commit,
    input  frame_t start_new,
    input  frame_t start_q,
    input  frame_t last_q,
    output frame_t cur_q,
    output logic   pending_q,
    output logic   wrap_q
);
    logic   at_last;
    logic   wrap_now;
    act_e   act;
    logic   pend_d;

    assign at_last  = (cur_q == last_q);
    assign wrap_now = frame_done && at_last;

    always_comb begin
        act    = ACT_KEEP;
        pend_d = pending_q;
        if (start_commit && !hold) begin
            act    = ACT_LOAD_NEW;
            pend_d = 1'b0;
        end else if (start_commit) begin
            if (wrap_now) begin
                act    = ACT_LOAD_NEW;
                pend_d = 1'b0;
            end else begin
                act    = frame_done ? ACT_STEP : ACT_KEEP;
                pend_d = 1'b1;
            end
        end else if (wrap_now) begin
            act    = ACT_LOAD_OLD;
            pend_d = 1'b0;
        end else if (frame_done) begin
            act    = ACT_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= START_RST;
            pending_q <= 1'b0;
            wrap_q    <= 1'b0;
        end else begin
            pending_q <= pend_d;
            wrap_q    <= wrap_now;
            unique case (act)
                ACT_STEP:     cur_q <= frame_inc(cur_q);
                ACT_LOAD_NEW: cur_q <= start_new;
                ACT_LOAD_OLD: cur_q <= start_q;
                default:      cur_q <= cur_q;
            endcase
        end
    end
endmodule

// File: rtl/fwc_read_port.sv
module fwc_read_port
    import fwc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rd_en,
    input  addr_t  rd_addr,
    input  frame_t cur_q,
    input  frame_t start_q,
    input  frame_t last_q,
    output byte_t  rd_data
);
    logic [LOW_W-1:0] snap_q;
    frame_t           cur_view;

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (rd_en && rd_addr.tgt == TGT_CUR && rd_addr.idx == '0)
            snap_q <= cur_q[FRAME_W-1:BYTE_W];
    end

    assign cur_view = {snap_q, cur_q[BYTE_W-1:0]};

    always_comb begin
        unique case (rd_addr.tgt)
            TGT_CUR:   rd_data = pick_byte(cur_view, rd_addr.idx);
            TGT_START: rd_data = pick_byte(start_q, rd_addr.idx);
            TGT_LAST:  rd_data = pick_byte(last_q, rd_addr.idx);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/frame_wrap_counter.sv
module frame_wrap_counter
    import fwc_pkg::*;
#(
    parameter frame_t START_RST = 16'd0,
    parameter frame_t LAST_RST  = 16'd12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              hold,
    input  logic              frame_done,
    output logic [FRAME_W-1:0] cur_frame,
    output logic              start_pending,
    output logic              wrap_pulse
);
    frame_t start_val;
    frame_t last_val;
    frame_t start_new;
    logic   start_commit;

    fwc_regfile #(.START_RST(START_RST), .LAST_RST(LAST_RST)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (addr_t'(wr_addr)),
        .wr_data      (wr_data),
        .start_q      (start_val),
        .last_q       (last_val),
        .start_commit (start_commit),
        .start_new    (start_new)
    );

    fwc_count_core #(.START_RST(START_RST)) u_core (
        .clk          (clk),
        .rst          (rst),
        .frame_done   (frame_done),
        .hold         (hold),
        .start_commit (start_commit),
        .start_new    (start_new),
        .start_q      (start_val),
        .last_q       (last_val),
        .cur_q        (cur_frame),
        .pending_q    (start_pending),
        .wrap_q       (wrap_pulse)
    );

    fwc_read_port u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .rd_addr (addr_t'(rd_addr)),
        .cur_q   (cur_frame),
        .start_q (start_val),
        .last_q  (last_val),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/fwc_checker.sv
module fwc_checker
    import fwc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              hold,
    input logic              frame_done,
    input logic [FRAME_W-1:0] cur_frame,
    input logic [FRAME_W-1:0] start_val,
    input logic [FRAME_W-1:0] last_val,
    input logic              start_pending,
    input logic              wrap_pulse
);
    logic s_hi, s_lo, l_lo, roll;
    assign s_hi = wr_en && wr_addr == 3'b011;
    assign s_lo = wr_en && wr_addr == 3'b010;
    assign l_lo = wr_en && wr_addr == 3'b100;
    assign roll = frame_done && cur_frame == last_val;

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !roll && !s_hi) |=> cur_frame == FRAME_W'($past(cur_frame) + 1'b1));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (roll && !s_hi) |=> (cur_frame == $past(start_val) && wrap_pulse && !start_pending));

    assert_lo_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (s_lo || l_lo) |=> ($stable(start_val) && $stable(last_val)));

    assert_jump_R5: assert property (@(posedge clk) disable iff (rst)
        (s_hi && !hold) |=> (cur_frame == start_val && !start_pending));

    assert_defer_R6: assert property (@(posedge clk) disable iff (rst)
        (s_hi && hold && !roll) |=> start_pending);

    assert_same_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (s_hi && hold && roll) |=> (cur_frame == start_val && !start_pending));
endmodule

bind frame_wrap_counter fwc_checker u_fwc_checker (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .hold          (hold),
    .frame_done    (frame_done),
    .cur_frame     (cur_frame),
    .start_val     (start_val),
    .last_val      (last_val),
    .start_pending (start_pending),
    .wrap_pulse    (wrap_pulse)
);

// File: tb/frame_wrap_counter_bench.sv
module frame_wrap_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] START_RST = 16'd0;
    localparam logic [15:0] LAST_RST  = 16'd12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 0, rd_en = 0, hold = 0, frame_done = 0;
    logic [2:0] wr_addr = 0, rd_addr = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic [15:0] cur_frame;
    logic start_pending, wrap_pulse;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [15:0] m_cur, m_start, m_last;
    logic [7:0]  m_stg_s, m_stg_l, m_snap;
    logic        m_pend, m_wrap;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_wrap_counter #(.START_RST(START_RST), .LAST_RST(LAST_RST)) u_frame_wrap_counter (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .hold(hold),
        .frame_done(frame_done), .cur_frame(cur_frame),
        .start_pending(start_pending), .wrap_pulse(wrap_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'b000: return m_cur[7:0];
            3'b001: return m_snap;
            3'b010: return m_start[7:0];
            3'b011: return m_start[15:8];
            3'b100: return m_last[7:0];
            3'b101: return m_last[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string cur_tag(input logic we, input logic [2:0] wa,
                                      input logic h, input logic fd);
        logic c = we && wa == 3'b011;
        logic w = fd && m_cur == m_last;
        if (c && !h) return "R5";
        if (c && w)  return "R8";
        if (c)       return "R6";
        if (w && m_pend) return "R7";
        if (w)       return "R3";
        if (we && wa == 3'b101) return "R9";
        if (we && !wa[0]) return "R4";
        return "R2";
    endfunction

    task automatic model_reset();
        m_cur = START_RST; m_start = START_RST; m_last = LAST_RST;
        m_stg_s = 0; m_stg_l = 0; m_snap = 0; m_pend = 0; m_wrap = 0;
    endtask

    task automatic model_step(input logic we, input logic [2:0] wa, input logic [7:0] wd,
                              input logic re, input logic [2:0] ra, input logic h, input logic fd);
        logic c = we && wa == 3'b011;
        logic w = fd && m_cur == m_last;
        logic [15:0] nv = {wd, m_stg_s};
        if (re && ra == 3'b000) m_snap = m_cur[15:8];
        m_wrap = w;
        if (c && (!h || w)) begin m_cur = nv; m_pend = 0; end
        else if (c) begin m_pend = 1; if (fd) m_cur = m_cur + 16'd1; end
        else if (w) begin m_cur = m_start; m_pend = 0; end
        else if (fd) m_cur = m_cur + 16'd1;
        if (c) m_start = nv;
        if (we && wa == 3'b101) m_last = {wd, m_stg_l};
        if (we && wa == 3'b010) m_stg_s = wd;
        if (we && wa == 3'b100) m_stg_l = wd;
    endtask

    task automatic cycle(input logic we, input logic [2:0] wa, input logic [7:0] wd,
                         input logic re, input logic [2:0] ra, input logic h, input logic fd);
        string tag;
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
        hold = h; frame_done = fd;
        #1;
        chk((ra[2:1] == 2'd0) ? "R10 read" : "R11 read", rd_data, exp_rd(ra));
        tag = cur_tag(we, wa, h, fd);
        @(posedge clk);
        model_step(we, wa, wd, re, ra, h, fd);
        #1;
        chk({tag, " count"}, cur_frame, m_cur);
        chk({tag, " pending"}, start_pending, m_pend);
        chk("R3 wrap", wrap_pulse, m_wrap);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(0, 3'b000, 0, 0, 3'b000, hold, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        chk("R1 count", cur_frame, START_RST);
        chk("R1 pending", start_pending, 0);
        chk("R1 wrap", wrap_pulse, 0);
        cycle(0, 0, 0, 0, 3'b101, 0, 0);
        cycle(0, 0, 0, 0, 3'b100, 0, 0);

        // R2/R3: run to the last frame and roll over
        for (int i = 0; i < 14; i++) cycle(0, 0, 0, 0, 3'b000, 0, 1);
        // R4: low byte staged only
        cycle(1, 3'b010, 8'd5, 0, 3'b010, 0, 0);
        // R5: immediate jump, overriding a strobe
        cycle(1, 3'b011, 8'd0, 0, 3'b011, 0, 1);
        // R6/R7: deferred start, consumed at wrap
        cycle(1, 3'b010, 8'd2, 0, 3'b000, 1, 0);
        cycle(1, 3'b011, 8'd0, 0, 3'b010, 1, 1);
        for (int i = 0; i < 9; i++) cycle(0, 0, 0, 0, 3'b000, 1, 1);
        // R8: drive to last, then commit and roll over together
        while (m_cur != m_last) cycle(0, 0, 0, 0, 3'b000, 1, 1);
        cycle(1, 3'b010, 8'd7, 0, 3'b000, 1, 0);
        cycle(1, 3'b011, 8'd0, 0, 3'b000, 1, 1);
        // R9: shrink last frame
        cycle(1, 3'b100, 8'd9, 0, 3'b100, 1, 0);
        cycle(1, 3'b101, 8'd0, 0, 3'b101, 1, 0);
        for (int i = 0; i < 4; i++) cycle(0, 0, 0, 0, 3'b000, 1, 1);
        // R10: latch upper byte, move counter, read latched byte
        cycle(1, 3'b010, 8'hF0, 0, 3'b000, 0, 0);
        cycle(1, 3'b011, 8'hAB, 0, 3'b000, 0, 0);
        cycle(0, 0, 0, 1, 3'b000, 0, 1);
        cycle(1, 3'b011, 8'h12, 0, 3'b001, 0, 0);
        cycle(0, 0, 0, 0, 3'b001, 0, 0);
        cycle(0, 0, 0, 0, 3'b110, 0, 0);
        // back to small frames
        cycle(1, 3'b010, 8'd0, 0, 3'b000, 0, 0);
        cycle(1, 3'b011, 8'd0, 0, 3'b000, 0, 0);
        cycle(1, 3'b100, 8'd10, 0, 3'b000, 0, 0);
        cycle(1, 3'b101, 8'd0, 0, 3'b000, 0, 0);

        for (int i = 0; i < 4000; i++) begin
            logic we = ($urandom % 100) < 18;
            logic [2:0] wa = 3'(3'b010 + ($urandom % 4));
            logic [7:0] wd = wa[0] ? (($urandom % 8) == 0 ? 8'($urandom) : 8'd0)
                                   : 8'($urandom % 21);
            logic re = ($urandom % 4) == 0;
            logic [2:0] ra = 3'($urandom % 8);
            logic h = ($urandom % 2) == 1;
            logic fd = ($urandom % 100) < 65;
            if (m_cur > m_last && m_cur > 16'd40 && !we) begin
                we = 1; wa = 3'b011; wd = 8'd0; h = 0;
            end
            cycle(we, wa, wd, re, ra, h, fd);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule